// File: doc/BRIEF.md
# Adaptive-rate SEC-DED memory scrubber

This block sweeps a single-port word memory whose words carry an extended Hamming code: check bits that correct any one flipped bit, plus an overall parity bit that exposes two flipped bits. It visits the addresses in order. At each address it reads the stored codeword and decodes it. If one bit is wrong, it writes the repaired codeword back to the same address, so isolated upsets are cleared before a second hit can turn them into an uncorrectable pair. A word with two bad bits is left untouched. The failure is recorded in a sticky flag, a saturating counter and a last-failing-address register.

The memory port is shared with a host. Whenever the host raises its request, it owns the port in that same cycle. A scrub step that is held off waits and then continues at the address it had reached. If the host writes the word whose repair is still pending, the repair is dropped and that word is read again. The pause between steps comes from a programmable interval input. A radiation-level input divides that interval by four, so the sweep runs faster while the environment is harsh.

Top module: `mem_scrubber`

## Requirements
- R1: A codeword has DATA_W+P+1 bits, with P the smallest count such that 2^P >= DATA_W+P+1 (72 bits for 64 data bits). Bit 0 is the even parity over all other bits. Bit i (1..DATA_W+P) is Hamming position i. Check bits sit at the power-of-two positions, and data bits fill the remaining positions in ascending order from data bit 0. The scrubber accepts every word encoded this way as clean.
- R2: A clean word is read but never written back.
- R3: A word with one flipped bit in any data or Hamming check position is rewritten with the original codeword, at the same address, by the scrubber's own write.
- R4: A single flipped bit in the overall parity position (bit 0) is also corrected and written back.
- R5: A word with two flipped bits is not written back. It sets dbl_flag, which stays set until reset, increments dbl_count, and loads its address into dbl_addr.
- R6: dbl_count stops at 2^ERR_W-1 and does not wrap.
- R7: While host_req is high, the memory port carries the host's enable, write strobe, address and data. A scrub step held off this way continues at the next address not yet read.
- R8: A host write to the address whose repair is pending cancels that repair, and the scrubber reads the address again.
- R9: The scrub address increases by one per step and wraps from the last address to 0. pass_done pulses for one cycle once per full sweep, after the last address completes and before address 0 is read.
- R10: With rad_high low, clean steps without host traffic issue reads every max(rate_interval,1)+3 cycles.
- R11: With rad_high high, the interval used is max(rate_interval>>2,1).
- R12: After reset dbl_flag, dbl_count, dbl_addr and pass_done are 0, the memory port is idle, and the sweep starts at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_interval | input | CNT_W | Programmed wait between scrub steps, in cycles |
| rad_high | input | 1 | High radiation level: use the interval divided by four |
| host_req | input | 1 | Host claims the memory port this cycle |
| host_we | input | 1 | Host write strobe |
| host_addr | input | ADDR_W | Host address |
| host_wdata | input | CW_W | Host write codeword |
| mem_en | output | 1 | Memory port enable |
| mem_we | output | 1 | Memory port write strobe |
| mem_addr | output | ADDR_W | Memory port address |
| mem_wdata | output | CW_W | Memory port write codeword |
| mem_rdata | input | CW_W | Memory read codeword, valid one cycle after a read |
| dbl_flag | output | 1 | Sticky uncorrectable-error flag |
| dbl_count | output | ERR_W | Saturating count of uncorrectable words |
| dbl_addr | output | ADDR_W | Address of the latest uncorrectable word |
| pass_done | output | 1 | One-cycle pulse at the end of each full sweep |

## Verification
The properties assume the memory returns read data exactly one cycle after a read, and that the host holds its request and address stable for whole cycles. The stimulus drives every input at the falling edge and models the memory with one cycle of read latency. It also takes care that no word receives a second upset before the sweep reaches it, except where a double error is the case under test. Host writes to the word under scrub occur only in the directed cancellation case. The random host bursts issue reads only, so the reference copy of memory stays exact.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

  // Number of Hamming check bits needed for dw data bits.
  function automatic int chk_bits(input int dw);
    int p;
    p = 0;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

  typedef enum logic [2:0] {
    S_WAIT,
    S_READ,
    S_CHECK,
    S_WRITE,
    S_NEXT
  } scrub_state_t;

endpackage

// File: rtl/secded_dec.sv
module secded_dec #(
  parameter int DATA_W = 64,
  localparam int P     = scrub_pkg::chk_bits(DATA_W),
  localparam int N     = DATA_W + P,
  localparam int CW_W  = N + 1
) (
  input  logic [CW_W-1:0] cw,
  output logic [CW_W-1:0] fixed,
  output logic            single,
  output logic            double
);

  logic [P-1:0] syn;
  logic         par;

  always_comb begin
    syn = '0;
    for (int i = 1; i <= N; i++) begin
      if (cw[i]) syn = syn ^ P'(i);
    end
    par = ^cw;
    // Odd parity means an odd number of flips: one bit, located by the syndrome.
    single = par && ((syn == '0) || (int'(syn) <= N));
    // Even parity with a nonzero syndrome, or a syndrome that points past the word.
    double = ((syn != '0) && !par) || (par && (int'(syn) > N));
    fixed  = cw;
    if (single) fixed = cw ^ (CW_W'(1) << syn);
  end

endmodule

// File: rtl/scrub_timer.sv
module scrub_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [CNT_W-1:0] rate,
  input  logic             rad_high,
  output logic             expired
);

  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] eff;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    base = rad_high ? (rate >> 2) : rate;
    eff  = (base == '0) ? CNT_W'(1) : base;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= CNT_W'(1);
    end else if (load) begin
      cnt <= eff;
    end else if (run && (cnt > CNT_W'(1))) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign expired = (cnt <= CNT_W'(1));

endmodule

// File: rtl/err_log.sv
module err_log #(
  parameter int ADDR_W = 4,
  parameter int ERR_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic [ADDR_W-1:0] addr,
  output logic              flag,
  output logic [ERR_W-1:0]  count,
  output logic [ADDR_W-1:0] last_addr
);

  localparam logic [ERR_W-1:0] CMAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag      <= 1'b0;
      count     <= '0;
      last_addr <= '0;
    end else if (hit) begin
      flag      <= 1'b1;
      last_addr <= addr;
      if (count != CMAX) count <= count + ERR_W'(1);
    end
  end

endmodule

// File: rtl/mem_scrubber.sv
module mem_scrubber #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 16,
  parameter int ERR_W  = 4,
  localparam int CW_W  = DATA_W + scrub_pkg::chk_bits(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  rate_interval,
  input  logic              rad_high,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [CW_W-1:0]   host_wdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [CW_W-1:0]   mem_wdata,
  input  logic [CW_W-1:0]   mem_rdata,
  output logic              dbl_flag,
  output logic [ERR_W-1:0]  dbl_count,
  output logic [ADDR_W-1:0] dbl_addr,
  output logic              pass_done
);

  import scrub_pkg::*;

  localparam logic [ADDR_W-1:0] LAST = '1;

  scrub_state_t      state;
  logic [ADDR_W-1:0] ptr;
  logic [CW_W-1:0]   fix_cw;
  logic [CW_W-1:0]   dec_fixed;
  logic              dec_single;
  logic              dec_double;
  logic              expired;
  logic              host_hits_ptr;

  secded_dec #(.DATA_W(DATA_W)) u_dec (
    .cw     (mem_rdata),
    .fixed  (dec_fixed),
    .single (dec_single),
    .double (dec_double)
  );

  scrub_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (state == S_NEXT),
    .run      (state == S_WAIT),
    .rate     (rate_interval),
    .rad_high (rad_high),
    .expired  (expired)
  );

  err_log #(.ADDR_W(ADDR_W), .ERR_W(ERR_W)) u_log (
    .clk       (clk),
    .rst       (rst),
    .hit       ((state == S_CHECK) && !host_hits_ptr && dec_double),
    .addr      (ptr),
    .flag      (dbl_flag),
    .count     (dbl_count),
    .last_addr (dbl_addr)
  );

  assign host_hits_ptr = host_req && host_we && (host_addr == ptr);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_WAIT;
      ptr       <= '0;
      fix_cw    <= '0;
      pass_done <= 1'b0;
    end else begin
      pass_done <= 1'b0;
      unique case (state)
        S_WAIT:  if (expired) state <= S_READ;
        S_READ:  if (!host_req) state <= S_CHECK;
        S_CHECK: begin
          if (host_hits_ptr) begin
            state <= S_READ;
          end else if (dec_single) begin
            fix_cw <= dec_fixed;
            state  <= S_WRITE;
          end else begin
            state <= S_NEXT;
          end
        end
        S_WRITE: begin
          if (host_hits_ptr)  state <= S_READ;
          else if (!host_req) state <= S_NEXT;
        end
        S_NEXT: begin
          ptr       <= ptr + 1'b1;
          pass_done <= (ptr == LAST);
          state     <= S_WAIT;
        end
        default: state <= S_WAIT;
      endcase
    end
  end

  // Host always wins the shared port.
  always_comb begin
    if (host_req) begin
      mem_en    = 1'b1;
      mem_we    = host_we;
      mem_addr  = host_addr;
      mem_wdata = host_wdata;
    end else begin
      mem_en    = (state == S_READ) || (state == S_WRITE);
      mem_we    = (state == S_WRITE);
      mem_addr  = ptr;
      mem_wdata = fix_cw;
    end
  end

endmodule

// File: rtl/scrub_checker.sv
module scrub_checker #(
  parameter int ADDR_W = 4,
  parameter int ERR_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              host_req,
  input logic              host_we,
  input logic [ADDR_W-1:0] host_addr,
  input logic              mem_en,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] ptr,
  input logic              dbl_flag,
  input logic [ERR_W-1:0]  dbl_count,
  input logic              pass_done
);

  localparam logic [ERR_W-1:0] CMAX = '1;

  p_host_owns_port_r7: assert property (@(posedge clk) disable iff (rst)
    host_req |-> (mem_en && (mem_we == host_we) && (mem_addr == host_addr)));

  p_writeback_in_place_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !host_req) |-> (mem_addr == ptr));

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    dbl_flag |=> dbl_flag);

  p_count_saturates_r6: assert property (@(posedge clk) disable iff (rst)
    (dbl_count == CMAX) |=> (dbl_count == CMAX));

  p_count_monotone_r5: assert property (@(posedge clk) disable iff (rst)
    (dbl_count != '0) |=> (dbl_count != '0));

  p_pass_one_cycle_r9: assert property (@(posedge clk) disable iff (rst)
    pass_done |=> !pass_done);

  p_pass_at_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    pass_done |-> (ptr == '0));

endmodule

bind mem_scrubber scrub_checker #(.ADDR_W(ADDR_W), .ERR_W(ERR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .host_req  (host_req),
  .host_we   (host_we),
  .host_addr (host_addr),
  .mem_en    (mem_en),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .ptr       (ptr),
  .dbl_flag  (dbl_flag),
  .dbl_count (dbl_count),
  .pass_done (pass_done)
);

// File: tb/sim_mem_scrubber.sv
module sim_mem_scrubber;

  localparam int DATA_W = 64;
  localparam int ADDR_W = 4;
  localparam int CNT_W  = 16;
  localparam int ERR_W  = 4;
  localparam int P      = scrub_pkg::chk_bits(DATA_W);
  localparam int N      = DATA_W + P;
  localparam int CW_W   = N + 1;
  localparam int NW     = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [CNT_W-1:0]  rate_interval = '0;
  logic              rad_high = 1'b0;
  logic              host_req = 1'b0;
  logic              host_we = 1'b0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic [CW_W-1:0]   host_wdata = '0;
  logic              mem_en, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [CW_W-1:0]   mem_wdata;
  logic [CW_W-1:0]   mem_rdata = '0;
  logic              dbl_flag;
  logic [ERR_W-1:0]  dbl_count;
  logic [ADDR_W-1:0] dbl_addr;
  logic              pass_done;

  logic [CW_W-1:0] mem    [NW];
  logic [CW_W-1:0] golden [NW];

  int n_chk = 0, n_fail = 0;
  int cyc = 0, rd_cnt = 0, wr_cnt = 0, pass_cnt = 0;
  int last_rd_cyc = 0, prev_rd_cyc = 0;
  int last_rd_addr = -1, last_wr_addr = -1;
  int seq_err = 0, port_err = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mem_scrubber #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .ERR_W(ERR_W)) u0 (
    .clk(clk), .rst(rst), .rate_interval(rate_interval), .rad_high(rad_high),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .dbl_flag(dbl_flag), .dbl_count(dbl_count),
    .dbl_addr(dbl_addr), .pass_done(pass_done)
  );

  // Memory model: one cycle read latency.
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
    end
  end

  // Port monitor, sampled away from the active edge.
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (host_req && (mem_addr != host_addr)) port_err++;
      if (mem_en && !host_req) begin
        if (mem_we) begin
          wr_cnt++;
          last_wr_addr = int'(mem_addr);
        end else begin
          if (last_rd_addr >= 0 && int'(mem_addr) != (last_rd_addr + 1) % NW
              && int'(mem_addr) != last_rd_addr) seq_err++;
          rd_cnt++;
          prev_rd_cyc  = last_rd_cyc;
          last_rd_cyc  = cyc;
          last_rd_addr = int'(mem_addr);
        end
      end
      if (pass_done) pass_cnt++;
    end
  end

  function automatic logic [CW_W-1:0] enc(input logic [DATA_W-1:0] d);
    logic [CW_W-1:0] cw;
    logic [P-1:0]    s;
    int k;
    cw = '0;
    k  = 0;
    for (int i = 1; i <= N; i++) begin
      if ((i & (i - 1)) != 0) begin
        cw[i] = d[k];
        k++;
      end
    end
    s = '0;
    for (int i = 1; i <= N; i++) if (cw[i]) s = s ^ P'(i);
    for (int j = 0; j < P; j++) cw[1 << j] = s[j];
    cw[0] = ^cw[N:1];
    return cw;
  endfunction

  function automatic logic [CW_W-1:0] rnd_cw();
    return enc({$urandom(), $urandom()});
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_reads(input int n);
    int start;
    start = rd_cnt;
    while (rd_cnt < start + n) @(negedge clk);
  endtask

  task automatic wait_read_of(input int a);
    int start;
    start = rd_cnt;
    while (!(rd_cnt > start && last_rd_addr == a)) @(negedge clk);
  endtask

  task automatic wait_write(input int limit);
    int start;
    start = wr_cnt;
    for (int i = 0; i < limit && wr_cnt == start; i++) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(10 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    int a, b, w0, c0;
    logic [CW_W-1:0] bad, nw;
    void'($urandom(32'd1234));
    for (int i = 0; i < NW; i++) begin
      golden[i] = rnd_cw();
      mem[i]    = golden[i];
    end
    cycles(3);
    rst = 1'b0;
    // R12: reset state
    chk("R12 flag", dbl_flag, 0);
    chk("R12 count", dbl_count, 0);
    chk("R12 addr", dbl_addr, 0);
    chk("R12 pass", pass_done, 0);
    chk("R12 port idle", mem_en, 0);
    wait_reads(1);
    chk("R12 first address", last_rd_addr, 0);

    // R10 / R11: step period
    rate_interval = 16'd6; rad_high = 0;
    wait_reads(3);
    chk("R10 period rate 6", last_rd_cyc - prev_rd_cyc, 9);
    rate_interval = 16'd0;
    wait_reads(3);
    chk("R10 period rate 0", last_rd_cyc - prev_rd_cyc, 4);
    rate_interval = 16'd20; rad_high = 1;
    wait_reads(3);
    chk("R11 period rate 20 high", last_rd_cyc - prev_rd_cyc, 8);
    rate_interval = 16'd3;
    wait_reads(3);
    chk("R11 period rate 3 high min", last_rd_cyc - prev_rd_cyc, 4);
    rad_high = 0; rate_interval = 16'd1;

    // R1 / R2 / R9: one clean pass
    wait_read_of(0);
    w0 = wr_cnt; c0 = pass_cnt;
    wait_reads(NW);
    chk("R9 wrapped to 0", last_rd_addr, 0);
    chk("R9 one pass pulse", pass_cnt - c0, 1);
    chk("R2 no writeback on clean", wr_cnt - w0, 0);
    b = 0;
    for (int i = 0; i < NW; i++) if (mem[i] !== golden[i]) b++;
    chk("R1 encoded words unchanged", b, 0);
    chk("R1 no double flag", dbl_flag, 0);

    // R3 / R4: single-bit repairs
    for (int it = 0; it < 16; it++) begin
      a = int'($urandom() % NW);
      case (it)
        0: b = 0; 1: b = 1; 2: b = 64; 3: b = N; 4: b = 3;
        default: b = int'($urandom() % CW_W);
      endcase
      mem[a] = mem[a] ^ (CW_W'(1) << b);
      wait_write(400);
      cycles(1);
      if (b == 0) begin
        chk("R4 parity bit repaired", mem[a], golden[a]);
        chk("R4 write address", last_wr_addr, a);
      end else begin
        chk($sformatf("R3 bit %0d repaired", b), mem[a], golden[a]);
        chk("R3 write address", last_wr_addr, a);
      end
    end

    // R5: double errors left in place and logged
    for (int it = 0; it < 2; it++) begin
      a   = (it == 0) ? 5 : 12;
      bad = golden[a] ^ (CW_W'(1) << (it == 0 ? 3 : 0)) ^ (CW_W'(1) << 40);
      mem[a] = bad;
      w0 = wr_cnt; c0 = int'(dbl_count);
      wait_read_of(a);
      cycles(3);
      chk("R5 no writeback", wr_cnt - w0, 0);
      chk("R5 word kept", mem[a], bad);
      chk("R5 flag", dbl_flag, 1);
      chk("R5 count", dbl_count, c0 + 1);
      chk("R5 address", dbl_addr, a);
      mem[a] = golden[a];
    end

    // R6: saturation
    for (int i = 0; i < NW; i++) mem[i] = golden[i] ^ CW_W'(6);
    wait_reads(2 * NW);
    chk("R6 saturated", dbl_count, (1 << ERR_W) - 1);
    for (int i = 0; i < NW; i++) mem[i] = golden[i];
    wait_reads(NW + 1);
    chk("R6 held", dbl_count, (1 << ERR_W) - 1);
    chk("R5 flag still set", dbl_flag, 1);

    // R7: host priority, scrub resumes
    wait_reads(1);
    a = last_rd_addr; c0 = rd_cnt;
    host_req = 1; host_we = 0;
    for (int i = 0; i < 40; i++) begin
      host_addr = ADDR_W'($urandom());
      @(negedge clk);
    end
    host_req = 0;
    chk("R7 no scrub access while host holds", rd_cnt - c0, 0);
    wait_reads(1);
    chk("R7 resumes at next address", last_rd_addr, (a + 1) % NW);

    // R8: host write cancels pending repair
    a = (last_rd_addr + 2) % NW;
    mem[a] = golden[a] ^ (CW_W'(1) << 17);
    nw = rnd_cw();
    while (!(mem_en && !mem_we && !host_req && int'(mem_addr) == a)) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    host_req = 1; host_we = 1; host_addr = ADDR_W'(a); host_wdata = nw;
    w0 = wr_cnt;
    @(negedge clk);
    host_req = 0; host_we = 0;
    cycles(8);
    golden[a] = nw;
    chk("R8 host data survives", mem[a], nw);
    chk("R8 repair cancelled", wr_cnt - w0, 0);

    // Random mix: single upsets with host read bursts
    for (int it = 0; it < 20; it++) begin
      a = int'($urandom() % NW);
      b = int'($urandom() % CW_W);
      mem[a] = mem[a] ^ (CW_W'(1) << b);
      for (int k = 0; k < int'($urandom() % 10); k++) begin
        host_req = 1; host_we = 0; host_addr = ADDR_W'($urandom());
        @(negedge clk);
      end
      host_req = 0;
      wait_write(600);
      cycles(1);
      chk($sformatf("R3 random repair bit %0d", b), mem[a], golden[a]);
    end

    chk("R9 address order", seq_err, 0);
    chk("R7 port ownership", port_err, 0);
    summary();
  end

endmodule